// File: doc/BRIEF.md
# PHY Loopback Configuration Sequencer

This block switches a transceiver's loopback on or off. It does this by issuing read-modify-write operations through an MDIO master. A one-cycle `start` pulse captures the on/off flag and a mode select. The block first asks a shared management lock for ownership, and only after the lock is granted does it talk to the master. In the direct mode it flips a single control bit in one register. In the probing mode it first reads the transceiver's identifier and picks the registers and bits to change from the value it gets back. For unrecognised identifiers it touches two registers, and the disable sequence walks them in the reverse order of the enable sequence.

Each read-modify-write is a complete read followed by a complete write to the same device and register. The write data is the read data with one bit set or cleared. Requests leave on a valid/ready channel. Once `req_valid` is high, the request fields are frozen until `req_ready` is seen. After acceptance the sequencer issues nothing more until the master answers with `rsp_valid`, so the master applies back-pressure simply by holding `req_ready` low. The response has no ready, because the sequencer always takes it. When the sequence ends, the block drops the lock request and pulses `done`, with `error` qualifying that pulse.

Top module: `phy_lpbk_seq`

## Requirements
- R1: After `start`, `lock_req` rises and no MDIO request is issued until `lock_grant` has been seen. A `lock_deny` ends the run with `done` and `error` both high, and no request is ever issued.
- R2: With `probe_mode`=0, the sequencer reads device 4 register 0xC000, then writes it back with bit 14 set (`lb_enable`=1) or cleared (`lb_enable`=0).
- R3: With `probe_mode`=1, the first request is a read of device 1 register 0x0002, which is the identifier, and it is not followed by a write.
- R4: If the identifier reads 0x0043 or 0x0240, the sequencer read-modify-writes device 1 register 0x0000. It sets bit 0 to enable and clears bit 0 to disable.
- R5: For any other identifier with `lb_enable`=1, the sequencer sets bit 2 of device 1 register 0xC017 first, and then sets bit 15 of device 4 register 0xC000.
- R6: For any other identifier with `lb_enable`=0, the sequencer clears bit 15 of device 4 register 0xC000 first, and then clears bit 2 of device 1 register 0xC017.
- R7: Every write targets the device and register of the read just before it. Its data equals the read data with only the target bit changed.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_write`, `req_dev`, `req_addr` and `req_wdata` stay unchanged. No new request starts before `rsp_valid` answers the previous one.
- R9: After the last write response, `lock_req` falls and `done` is high for exactly one cycle, in the first cycle with `lock_req` low. `error` is 0 on a successful run. Out of reset, `done`, `error`, `lock_req` and `req_valid` are all low.
- R10: A response with `rsp_err` high aborts the sequence. No further request is issued, the lock is released, and `done` pulses with `error` high.
- R11: A `start` pulse while a sequence is in progress is ignored. It neither restarts the sequence nor changes the captured on/off flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run a sequence |
| lb_enable | input | 1 | 1 turns loopback on, 0 turns it off; sampled with `start` |
| probe_mode | input | 1 | 0 selects the direct mode, 1 selects the identifier-probing mode |
| lock_req | output | 1 | High while the sequencer wants or holds the management lock |
| lock_grant | input | 1 | One-cycle pulse granting the lock |
| lock_deny | input | 1 | One-cycle pulse refusing the lock |
| req_valid | output | 1 | MDIO request valid |
| req_ready | input | 1 | MDIO master accepts the request |
| req_write | output | 1 | 1 for a write, 0 for a read |
| req_dev | output | 5 | Device address of the request |
| req_addr | output | 16 | Register address of the request |
| req_wdata | output | 16 | Write data |
| rsp_valid | input | 1 | One-cycle pulse when the master has finished the operation |
| rsp_rdata | input | 16 | Read data, valid with `rsp_valid` |
| rsp_err | input | 1 | The finished operation failed |
| done | output | 1 | One-cycle end-of-sequence pulse |
| error | output | 1 | Qualifies `done`: the run failed |

## Verification
The main function is driven by a table of runs that crosses mode, direction and identifier. Direct mode is run both ways, which tells set from clear on bit 14. Probing mode uses each of the two matching identifiers, which tells the single-register path from the two-register path. Unknown identifiers are run in both directions, which tells the enable order from the reversed disable order. Starting register values include the target bit already at its final state and the other bits at all-ones or all-zeros, so a write that disturbs a neighbouring bit or skips the modify step shows up. A master that holds `req_ready` low for a varying number of cycles tests that request fields stay frozen under back-pressure.

// File: rtl/lpbk_pkg.sv
package lpbk_pkg;
  parameter int DEV_W  = 5;
  parameter int ADDR_W = 16;
  parameter int DATA_W = 16;
  parameter int BIT_W  = $clog2(DATA_W);
  parameter int STEP_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOCK,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_FINISH
  } seq_state_e;

  // One step of a sequence: where to go, which bit, and how it ends
  typedef struct packed {
    logic [DEV_W-1:0]  dev;
    logic [ADDR_W-1:0] addr;
    logic [BIT_W-1:0]  bitpos;
    logic              rd_only;
    logic              last;
  } step_t;
endpackage

// File: rtl/lpbk_step_table.sv
module lpbk_step_table
  import lpbk_pkg::*;
#(
  parameter logic [DEV_W-1:0]  XS_DEV    = 5'd4,
  parameter logic [DEV_W-1:0]  PMA_DEV   = 5'd1,
  parameter logic [ADDR_W-1:0] VEND_REG  = 16'hC000,
  parameter logic [ADDR_W-1:0] LPEN_REG  = 16'hC017,
  parameter logic [ADDR_W-1:0] CTRL_REG  = 16'h0000,
  parameter logic [ADDR_W-1:0] ID_REG    = 16'h0002,
  parameter logic [BIT_W-1:0]  SIMPLE_BIT = 4'd14,
  parameter logic [BIT_W-1:0]  VEND_BIT   = 4'd15,
  parameter logic [BIT_W-1:0]  LPEN_BIT   = 4'd2,
  parameter logic [BIT_W-1:0]  CTRL_BIT   = 4'd0
) (
  input  logic              probe,
  input  logic              enable,
  input  logic              id_match,
  input  logic [STEP_W-1:0] step,
  output step_t             cur
);
  step_t vend_s, lpen_s;

  always_comb begin
    vend_s = '{dev: XS_DEV,  addr: VEND_REG, bitpos: VEND_BIT, rd_only: 1'b0, last: 1'b0};
    lpen_s = '{dev: PMA_DEV, addr: LPEN_REG, bitpos: LPEN_BIT, rd_only: 1'b0, last: 1'b0};
    cur    = '{dev: XS_DEV,  addr: VEND_REG, bitpos: SIMPLE_BIT, rd_only: 1'b0, last: 1'b1};
    if (probe) begin
      case (step)
        2'd0: cur = '{dev: PMA_DEV, addr: ID_REG, bitpos: '0, rd_only: 1'b1, last: 1'b0};
        2'd1: begin
          if (id_match)
            cur = '{dev: PMA_DEV, addr: CTRL_REG, bitpos: CTRL_BIT, rd_only: 1'b0, last: 1'b1};
          else
            cur = enable ? lpen_s : vend_s;   // disable walks the pair in reverse
        end
        default: begin
          cur      = enable ? vend_s : lpen_s;
          cur.last = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/lpbk_bit_mod.sv
module lpbk_bit_mod
  import lpbk_pkg::*;
(
  input  logic [DATA_W-1:0] rd_val,
  input  logic [BIT_W-1:0]  bitpos,
  input  logic              set,
  output logic [DATA_W-1:0] wr_val
);
  logic [DATA_W-1:0] mask;

  always_comb begin
    mask   = {{(DATA_W-1){1'b0}}, 1'b1} << bitpos;
    wr_val = set ? (rd_val | mask) : (rd_val & ~mask);
  end
endmodule

// File: rtl/phy_lpbk_seq.sv
module phy_lpbk_seq
  import lpbk_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_MATCH_A = 16'h0043,
  parameter logic [DATA_W-1:0] ID_MATCH_B = 16'h0240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              lb_enable,
  input  logic              probe_mode,
  output logic              lock_req,
  input  logic              lock_grant,
  input  logic              lock_deny,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [DEV_W-1:0]  req_dev,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata,
  input  logic              rsp_err,
  output logic              done,
  output logic              error
);
  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic              on_q, probe_q, id_match_q, err_q;
  logic [DATA_W-1:0] wdata_q, mod_val;
  step_t             cur;

  lpbk_step_table u_table (
    .probe    (probe_q),
    .enable   (on_q),
    .id_match (id_match_q),
    .step     (step_q),
    .cur      (cur)
  );

  lpbk_bit_mod u_mod (
    .rd_val (rsp_rdata),
    .bitpos (cur.bitpos),
    .set    (on_q),
    .wr_val (mod_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      step_q     <= '0;
      on_q       <= 1'b0;
      probe_q    <= 1'b0;
      id_match_q <= 1'b0;
      err_q      <= 1'b0;
      wdata_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          on_q       <= lb_enable;
          probe_q    <= probe_mode;
          step_q     <= '0;
          err_q      <= 1'b0;
          id_match_q <= 1'b0;
          state_q    <= ST_LOCK;
        end
        ST_LOCK: begin
          if (lock_deny) begin
            err_q   <= 1'b1;
            state_q <= ST_FINISH;
          end else if (lock_grant) begin
            state_q <= ST_RD_REQ;
          end
        end
        ST_RD_REQ: if (req_ready) state_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (rsp_valid) begin
          if (rsp_err) begin
            err_q   <= 1'b1;
            state_q <= ST_FINISH;
          end else if (cur.rd_only) begin
            id_match_q <= (rsp_rdata == ID_MATCH_A) || (rsp_rdata == ID_MATCH_B);
            step_q     <= step_q + 1'b1;
            state_q    <= ST_RD_REQ;
          end else begin
            wdata_q <= mod_val;
            state_q <= ST_WR_REQ;
          end
        end
        ST_WR_REQ: if (req_ready) state_q <= ST_WR_WAIT;
        ST_WR_WAIT: if (rsp_valid) begin
          if (rsp_err) begin
            err_q   <= 1'b1;
            state_q <= ST_FINISH;
          end else if (cur.last) begin
            state_q <= ST_FINISH;
          end else begin
            step_q  <= step_q + 1'b1;
            state_q <= ST_RD_REQ;
          end
        end
        ST_FINISH: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    lock_req  = (state_q != ST_IDLE) && (state_q != ST_FINISH);
    req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
    req_write = (state_q == ST_WR_REQ);
    req_dev   = cur.dev;
    req_addr  = cur.addr;
    req_wdata = wdata_q;
    done      = (state_q == ST_FINISH);
    error     = (state_q == ST_FINISH) && err_q;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_write) && $stable(req_dev)
      && $stable(req_addr) && $stable(req_wdata)); // R8
  AST_REQ_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> lock_req); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !lock_req && !req_valid); // R9
  AST_ERR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done); // R10
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err && lock_req |=> !req_valid); // R10
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_write) |-> $stable(req_dev) && $stable(req_addr)); // R7
endmodule

// File: tb/phy_lpbk_seq_tb_top.sv
`timescale 1ns/1ps
module phy_lpbk_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, lb_enable = 1'b0, probe_mode = 1'b0;
  logic lock_req, lock_grant = 1'b0, lock_deny = 1'b0;
  logic req_valid, req_ready = 1'b0, req_write;
  logic [4:0]  req_dev;
  logic [15:0] req_addr, req_wdata;
  logic rsp_valid = 1'b0, rsp_err = 1'b0;
  logic [15:0] rsp_rdata = '0;
  logic done, error;

  always #2 clk = ~clk;

  phy_lpbk_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .lb_enable(lb_enable), .probe_mode(probe_mode),
    .lock_req(lock_req), .lock_grant(lock_grant), .lock_deny(lock_deny),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_dev(req_dev), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .done(done), .error(error));

  int n_cmp = 0, n_bad = 0;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- bench model of the MDIO master and register file
  logic [15:0] m_vend, m_lpen, m_ctrl, m_id;
  logic [4:0]  lg_dev [8];
  logic [15:0] lg_addr [8];
  logic        lg_wr [8];
  int n_ops = 0, err_at = -1, sl_st = 0, wait_c = 0;
  logic stab_bad = 1'b0;
  logic [37:0] snap;
  logic deny_mode = 1'b0, lk_done = 1'b0;
  int lk_c = 0;

  function automatic logic [15:0] mread(input logic [4:0] d, input logic [15:0] a);
    if (d == 5'd4 && a == 16'hC000) return m_vend;
    if (d == 5'd1 && a == 16'hC017) return m_lpen;
    if (d == 5'd1 && a == 16'h0000) return m_ctrl;
    if (d == 5'd1 && a == 16'h0002) return m_id;
    return 16'hBAD0;
  endfunction

  always @(negedge clk) begin
    case (sl_st)
      0: if (req_valid) begin
        snap   = {req_write, req_dev, req_addr, req_wdata};
        wait_c = n_ops % 3;
        sl_st  = 1;
      end
      1: begin
        if (!req_valid || snap != {req_write, req_dev, req_addr, req_wdata}) stab_bad = 1'b1;
        if (wait_c == 0) begin req_ready = 1'b1; sl_st = 2; end
        else wait_c--;
      end
      2: begin
        req_ready = 1'b0;
        rsp_err   = (n_ops == err_at);
        rsp_rdata = mread(snap[36:32], snap[31:16]);
        if (snap[37] && !rsp_err) begin
          if (snap[36:32] == 5'd4 && snap[31:16] == 16'hC000) m_vend = snap[15:0];
          if (snap[36:32] == 5'd1 && snap[31:16] == 16'hC017) m_lpen = snap[15:0];
          if (snap[36:32] == 5'd1 && snap[31:16] == 16'h0000) m_ctrl = snap[15:0];
        end
        if (n_ops < 8) begin
          lg_wr[n_ops] = snap[37]; lg_dev[n_ops] = snap[36:32]; lg_addr[n_ops] = snap[31:16];
        end
        n_ops++;
        sl_st = 3;
      end
      3: begin rsp_valid = 1'b1; sl_st = 4; end
      default: begin rsp_valid = 1'b0; rsp_err = 1'b0; sl_st = 0; end
    endcase
  end

  // lock arbiter model
  always @(negedge clk) begin
    lock_grant = 1'b0; lock_deny = 1'b0;
    if (!lock_req) begin lk_done = 1'b0; lk_c = 0; end
    else if (!lk_done) begin
      lk_c++;
      if (lk_c == 2) begin
        if (deny_mode) lock_deny = 1'b1; else lock_grant = 1'b1;
        lk_done = 1'b1;
      end
    end
  end

  // ---------------- expected op list
  logic [4:0]  ex_dev [6];
  logic [15:0] ex_addr [6];
  logic        ex_wr [6];
  int n_exp;

  task automatic add_rmw(input logic [4:0] d, input logic [15:0] a);
    ex_dev[n_exp] = d; ex_addr[n_exp] = a; ex_wr[n_exp] = 1'b0; n_exp++;
    ex_dev[n_exp] = d; ex_addr[n_exp] = a; ex_wr[n_exp] = 1'b1; n_exp++;
  endtask

  task automatic build_exp(input logic pr, input logic on, input logic match);
    n_exp = 0;
    if (!pr) add_rmw(5'd4, 16'hC000);
    else begin
      ex_dev[0] = 5'd1; ex_addr[0] = 16'h0002; ex_wr[0] = 1'b0; n_exp = 1;
      if (match) add_rmw(5'd1, 16'h0000);
      else if (on) begin add_rmw(5'd1, 16'hC017); add_rmw(5'd4, 16'hC000); end
      else begin add_rmw(5'd4, 16'hC000); add_rmw(5'd1, 16'hC017); end
    end
  endtask

  logic d_err, d_lock;

  task automatic run(input logic pr, input logic on);
    @(negedge clk);
    n_ops = 0; stab_bad = 1'b0;
    start = 1'b1; lb_enable = on; probe_mode = pr;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    d_err = error; d_lock = lock_req;
    check(t < 5000, tag, t, 5000);
  endtask

  typedef struct packed {
    logic pr; logic on;
    logic [15:0] id, vend, lpen, ctrl;
  } vec_t;
  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b1, 16'h0000, 16'h1234, 16'h0000, 16'h0000},
    '{1'b0, 1'b0, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000},
    '{1'b1, 1'b1, 16'h0043, 16'h0000, 16'h0000, 16'hA5A4},
    '{1'b1, 1'b0, 16'h0240, 16'hFFFF, 16'hFFFF, 16'h00FF},
    '{1'b1, 1'b1, 16'h1234, 16'h0001, 16'h0000, 16'h0000},
    '{1'b1, 1'b0, 16'h0042, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    '{1'b1, 1'b1, 16'h0240, 16'h0000, 16'h0000, 16'h0001},
    '{1'b0, 1'b1, 16'h0000, 16'h4000, 16'h0000, 16'h0000}
  };

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9: quiet outputs out of reset
    check(!done && !error && !lock_req && !req_valid, "R9 reset outputs",
          {done, error, lock_req, req_valid}, 0);
    rst_n = 1'b1;

    for (int v = 0; v < 8; v++) begin
      logic match, sel;
      logic [15:0] e_vend, e_lpen, e_ctrl;
      string tg;
      m_vend = VEC[v].vend; m_lpen = VEC[v].lpen; m_ctrl = VEC[v].ctrl; m_id = VEC[v].id;
      match = (VEC[v].id == 16'h0043) || (VEC[v].id == 16'h0240);
      build_exp(VEC[v].pr, VEC[v].on, match);
      e_vend = VEC[v].vend; e_lpen = VEC[v].lpen; e_ctrl = VEC[v].ctrl;
      if (!VEC[v].pr) begin e_vend[14] = VEC[v].on; tg = "R2"; end
      else if (match) begin e_ctrl[0] = VEC[v].on; tg = "R4"; end
      else begin e_vend[15] = VEC[v].on; e_lpen[2] = VEC[v].on; tg = VEC[v].on ? "R5" : "R6"; end
      run(VEC[v].pr, VEC[v].on);
      wait_done({tg, " run completes"});
      check(!d_err && !d_lock, "R9 done clean, lock released", {d_err, d_lock}, 0);
      check(n_ops == n_exp, {tg, " op count"}, n_ops, n_exp);
      for (int k = 0; k < 6; k++) begin
        if (k < n_exp && k < n_ops) begin
          sel = (VEC[v].pr && k == 0);
          check(lg_dev[k] == ex_dev[k] && lg_addr[k] == ex_addr[k] && lg_wr[k] == ex_wr[k],
                sel ? "R3 identifier read first" : {tg, " op order"},
                {lg_wr[k], 10'd0, lg_dev[k], lg_addr[k]}, {ex_wr[k], 10'd0, ex_dev[k], ex_addr[k]});
        end
      end
      check(m_vend == e_vend, "R7 vendor reg value", m_vend, e_vend);
      check(m_lpen == e_lpen, "R7 enable reg value", m_lpen, e_lpen);
      check(m_ctrl == e_ctrl, "R7 control reg value", m_ctrl, e_ctrl);
      check(!stab_bad, "R8 request held under back-pressure", stab_bad, 0);
      repeat (3) @(negedge clk);
    end

    // R1: refused lock
    deny_mode = 1'b1;
    run(1'b0, 1'b1);
    wait_done("R1 deny completes");
    check(d_err, "R1 error on deny", d_err, 1);
    check(n_ops == 0, "R1 no MDIO op on deny", n_ops, 0);
    deny_mode = 1'b0;
    repeat (3) @(negedge clk);

    // R10: failing response on the second op of an unknown-id enable
    m_id = 16'h7777; m_vend = 16'h0000; m_lpen = 16'h0000; err_at = 1;
    run(1'b1, 1'b1);
    wait_done("R10 abort completes");
    check(d_err && !d_lock, "R10 error with lock released", {d_err, d_lock}, 2'b10);
    repeat (20) @(negedge clk);
    check(n_ops == 2, "R10 no op after failure", n_ops, 2);
    check(m_lpen == 16'h0000 && m_vend == 16'h0000, "R10 registers untouched",
          {m_vend, m_lpen}, 0);
    err_at = -1;

    // R11: second start while busy
    m_vend = 16'h0000;
    run(1'b0, 1'b1);
    repeat (3) @(negedge clk);
    start = 1'b1; lb_enable = 1'b0; probe_mode = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R11 run completes");
    repeat (40) @(negedge clk);
    check(n_ops == 2, "R11 busy start ignored, op count", n_ops, 2);
    check(m_vend == 16'h4000, "R11 on flag kept", m_vend, 16'h4000);

    finish_run();
  end
endmodule